// File: doc/BRIEF.md
# Blocking Cache Miss Buffer

This block tracks the requests a blocking cache has sent to memory. It has exactly two slots. One holds a single outstanding fill miss. The other holds a single outstanding write that expects no reply: either a dirty-line writeback or a write miss that bypasses allocation. While the fill slot is occupied the cache is held blocked. The buffer offers one request at a time to the memory bus and converts the cache-side request into a bus command code. A transmission error leaves the request waiting for retry. A matching fill reply releases the slot.

The buffer also supports squashing by thread ID. A squash drops an unsent request, or strips the cache target from a fill that has already been sent. It offers combinational address lookups against both slots, which the cache uses to detect conflicts with in-flight requests. A request that would need a second target in an occupied slot is refused and flagged. It is never merged.

Top module: `miss_buf`

## Requirements
- R1: After reset both slots are empty: `blocked_o`, `miss_cnt_o` and `bus_req_o` are 0.
- R2: A miss takes the fill path when it is a read (`miss_wr_i`=0) or when `wr_alloc_i`=1. If the fill slot is empty it is loaded. From the next cycle `blocked_o`=1, `miss_cnt_o`=1 and the request is pending. Its bus code is 0 for a read and 1 for a write (read-for-ownership).
- R3: With `wr_alloc_i`=0, a write miss goes to the write slot with bus code 2 (plain write) and leaves `blocked_o` at 0.
- R4: `err_o` is 1 in the same cycle, and the occupied slot is left unchanged, in each of these cases:
  - a fill-path miss arrives while the fill slot is valid;
  - a writeback arrives while the write slot is valid;
  - a no-fill write miss arrives while the write slot is valid;
  - a no-fill write miss arrives in the same cycle as a writeback, which wins.
  A `wb_req_i` writeback carries bus code 3.
- R5: `bus_req_o`=1 whenever a slot holds a request not yet in service. The write slot is preferred when both are pending (`bus_sel_o`=1 for the write slot, 0 for the fill slot). `bus_addr_o`, `bus_tid_o` and `bus_cmd_o` show the selected request.
- R6: A send happens when `bus_req_o` and `bus_gnt_i` are both 1. If `bus_err_i`=1 in that cycle, nothing changes: the same request with the same bus code is offered again.
- R7: A successful send from the write slot (code 2 or 3) frees that slot in the next cycle.
- R8: A successful send from the fill slot marks it in service. It stops being pending, and `blocked_o` stays 1.
- R9: A fill reply releases the in-service fill slot only when `rsp_addr_i` equals its address. `blocked_o` then falls in the next cycle, and `rsp_fwd_o`=1 in the reply cycle if the target was kept. A reply with any other address is ignored.
- R10: A squash removes any unsent request whose thread equals `sq_tid_i`, taking priority over a send in the same cycle. For an in-service fill it clears the target only, so the later reply frees the slot with `rsp_fwd_o`=0.
- R11: `lk_miss_hit_o` and `lk_wb_hit_o` are 1 in the same cycle when `lk_addr_i` equals the address of the valid fill slot or the valid write slot, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_alloc_i | input | 1 | Write misses take the fill path |
| miss_req_i | input | 1 | Miss request from cache |
| miss_wr_i | input | 1 | Miss is a write |
| miss_addr_i | input | AW | Miss block address |
| miss_tid_i | input | TW | Miss thread ID |
| wb_req_i | input | 1 | Writeback request from cache |
| wb_addr_i | input | AW | Writeback address |
| wb_tid_i | input | TW | Writeback thread ID |
| err_o | output | 1 | Request refused, slot occupied |
| bus_req_o | output | 1 | A request is pending |
| bus_sel_o | output | 1 | 1 = write slot offered, 0 = fill slot |
| bus_addr_o | output | AW | Offered address |
| bus_tid_o | output | TW | Offered thread ID |
| bus_cmd_o | output | 2 | Offered bus code (0 read, 1 read-own, 2 write, 3 writeback) |
| bus_gnt_i | input | 1 | Bus takes the offered request |
| bus_err_i | input | 1 | Transmission failed this cycle |
| rsp_valid_i | input | 1 | Fill reply present |
| rsp_addr_i | input | AW | Fill reply address |
| rsp_fwd_o | output | 1 | Reply is returned to the cache |
| sq_valid_i | input | 1 | Squash request |
| sq_tid_i | input | TW | Thread to squash |
| lk_addr_i | input | AW | Lookup address |
| lk_miss_hit_o | output | 1 | Lookup matches fill slot |
| lk_wb_hit_o | output | 1 | Lookup matches write slot |
| blocked_o | output | 1 | Cache is blocked |
| miss_cnt_o | output | 1 | Outstanding miss count (0 or 1) |

## Verification
Some outputs are combinational on the current state and inputs: `err_o`, `rsp_fwd_o`, the lookup hits and the offered bus fields. Others are registered and change one edge after the triggering input: slot contents, `blocked_o`, `miss_cnt_o` and hence `bus_req_o`. The bench drives inputs just after a falling edge and checks the combinational results two nanoseconds later, against a model holding the pre-edge state. It then advances the model and checks the registered outputs at the next falling edge, one cycle after the stimulus. Directed sequences cover error retry, reply address mismatch, write-slot priority and squash of sent and unsent requests. Random traffic follows, with write-allocate switched between phases.

// File: rtl/miss_buf_pkg.sv
package miss_buf_pkg;
  typedef enum logic [1:0] {
    BC_RD  = 2'd0,
    BC_RDX = 2'd1,
    BC_WR  = 2'd2,
    BC_WB  = 2'd3
  } bus_cmd_e;

  localparam int SLOT_MISS = 0;
  localparam int SLOT_WB   = 1;
  localparam int NSLOT     = 2;

  function automatic logic needs_rsp(bus_cmd_e c);
    return (c == BC_RD) || (c == BC_RDX);
  endfunction
endpackage

// File: rtl/mb_slot.sv
module mb_slot
  import miss_buf_pkg::*;
#(
  parameter int AW = 32,
  parameter int TW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_i,
  input  logic [AW-1:0] alloc_addr_i,
  input  logic [TW-1:0] alloc_tid_i,
  input  bus_cmd_e      alloc_cmd_i,
  input  logic          sq_i,
  input  logic [TW-1:0] sq_tid_i,
  input  logic          sent_i,
  input  logic          rsp_i,
  output logic          vld_o,
  output logic          busy_o,
  output logic          tgt_o,
  output logic [AW-1:0] addr_o,
  output logic [TW-1:0] tid_o,
  output bus_cmd_e      cmd_o
);
  logic          vld_q, busy_q, tgt_q;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] tid_q;
  bus_cmd_e      cmd_q;
  logic          sq_hit;

  assign sq_hit = sq_i && vld_q && (tid_q == sq_tid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      busy_q <= 1'b0;
      tgt_q  <= 1'b0;
      addr_q <= '0;
      tid_q  <= '0;
      cmd_q  <= BC_RD;
    end else if (alloc_i) begin
      vld_q  <= 1'b1;
      busy_q <= 1'b0;
      tgt_q  <= 1'b1;
      addr_q <= alloc_addr_i;
      tid_q  <= alloc_tid_i;
      cmd_q  <= alloc_cmd_i;
    end else if (rsp_i) begin
      vld_q  <= 1'b0;
      busy_q <= 1'b0;
    end else if (sq_hit) begin
      // sent fill keeps its slot, loses its target
      if (busy_q) tgt_q <= 1'b0;
      else        vld_q <= 1'b0;
    end else if (sent_i) begin
      if (needs_rsp(cmd_q)) busy_q <= 1'b1;
      else                  vld_q  <= 1'b0;
    end
  end

  assign vld_o  = vld_q;
  assign busy_o = busy_q;
  assign tgt_o  = tgt_q;
  assign addr_o = addr_q;
  assign tid_o  = tid_q;
  assign cmd_o  = cmd_q;

  // R7
  no_rsp_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_i && !needs_rsp(cmd_q) && !alloc_i |=> !vld_q);

  // R8
  in_service_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_i && needs_rsp(cmd_q) && !sq_hit && !alloc_i && !rsp_i |=> vld_q && busy_q);
endmodule

// File: rtl/mb_pick.sv
module mb_pick
  import miss_buf_pkg::*;
(
  input  logic [NSLOT-1:0] pend_i,
  output logic             req_o,
  output logic             sel_o
);
  assign req_o = |pend_i;
  // writeback drains first
  assign sel_o = pend_i[SLOT_WB];

  // R5
  sel_pending_chk: assert final (!req_o || pend_i[sel_o]);
endmodule

// File: rtl/miss_buf.sv
module miss_buf
  import miss_buf_pkg::*;
#(
  parameter int AW = 32,
  parameter int TW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_alloc_i,
  input  logic          miss_req_i,
  input  logic          miss_wr_i,
  input  logic [AW-1:0] miss_addr_i,
  input  logic [TW-1:0] miss_tid_i,
  input  logic          wb_req_i,
  input  logic [AW-1:0] wb_addr_i,
  input  logic [TW-1:0] wb_tid_i,
  output logic          err_o,
  output logic          bus_req_o,
  output logic          bus_sel_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [TW-1:0] bus_tid_o,
  output logic [1:0]    bus_cmd_o,
  input  logic          bus_gnt_i,
  input  logic          bus_err_i,
  input  logic          rsp_valid_i,
  input  logic [AW-1:0] rsp_addr_i,
  output logic          rsp_fwd_o,
  input  logic          sq_valid_i,
  input  logic [TW-1:0] sq_tid_i,
  input  logic [AW-1:0] lk_addr_i,
  output logic          lk_miss_hit_o,
  output logic          lk_wb_hit_o,
  output logic          blocked_o,
  output logic [0:0]    miss_cnt_o
);
  logic [NSLOT-1:0] alloc, sent, rsp_s, vld, busy, tgt, pend;
  logic [AW-1:0]    a_addr [NSLOT];
  logic [TW-1:0]    a_tid  [NSLOT];
  bus_cmd_e         a_cmd  [NSLOT];
  logic [AW-1:0]    s_addr [NSLOT];
  logic [TW-1:0]    s_tid  [NSLOT];
  bus_cmd_e         s_cmd  [NSLOT];
  logic             fill_req, nofill_req, sel, rsp_match;

  assign fill_req   = miss_req_i && (!miss_wr_i || wr_alloc_i);
  assign nofill_req = miss_req_i && miss_wr_i && !wr_alloc_i;

  always_comb begin
    alloc[SLOT_MISS]  = fill_req && !vld[SLOT_MISS];
    a_addr[SLOT_MISS] = miss_addr_i;
    a_tid[SLOT_MISS]  = miss_tid_i;
    a_cmd[SLOT_MISS]  = miss_wr_i ? BC_RDX : BC_RD;
    alloc[SLOT_WB]    = !vld[SLOT_WB] && (wb_req_i || nofill_req);
    a_addr[SLOT_WB]   = wb_req_i ? wb_addr_i : miss_addr_i;
    a_tid[SLOT_WB]    = wb_req_i ? wb_tid_i : miss_tid_i;
    a_cmd[SLOT_WB]    = wb_req_i ? BC_WB : BC_WR;
  end

  assign err_o = (fill_req && vld[SLOT_MISS])
              || (wb_req_i && vld[SLOT_WB])
              || (nofill_req && (vld[SLOT_WB] || wb_req_i));

  assign pend = vld & ~busy;

  mb_pick u_pick (
    .pend_i (pend),
    .req_o  (bus_req_o),
    .sel_o  (sel)
  );

  assign bus_sel_o  = sel;
  assign bus_addr_o = s_addr[sel];
  assign bus_tid_o  = s_tid[sel];
  assign bus_cmd_o  = s_cmd[sel];

  assign rsp_match = rsp_valid_i && vld[SLOT_MISS] && busy[SLOT_MISS]
                  && (rsp_addr_i == s_addr[SLOT_MISS]);
  assign rsp_s[SLOT_MISS] = rsp_match;
  assign rsp_s[SLOT_WB]   = 1'b0;
  assign rsp_fwd_o        = rsp_match && tgt[SLOT_MISS];

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    assign sent[k] = bus_req_o && bus_gnt_i && !bus_err_i && (sel == 1'(k));
    mb_slot #(.AW(AW), .TW(TW)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .alloc_i      (alloc[k]),
      .alloc_addr_i (a_addr[k]),
      .alloc_tid_i  (a_tid[k]),
      .alloc_cmd_i  (a_cmd[k]),
      .sq_i         (sq_valid_i),
      .sq_tid_i     (sq_tid_i),
      .sent_i       (sent[k]),
      .rsp_i        (rsp_s[k]),
      .vld_o        (vld[k]),
      .busy_o       (busy[k]),
      .tgt_o        (tgt[k]),
      .addr_o       (s_addr[k]),
      .tid_o        (s_tid[k]),
      .cmd_o        (s_cmd[k])
    );
  end

  assign lk_miss_hit_o = vld[SLOT_MISS] && (lk_addr_i == s_addr[SLOT_MISS]);
  assign lk_wb_hit_o   = vld[SLOT_WB] && (lk_addr_i == s_addr[SLOT_WB]);
  assign blocked_o     = vld[SLOT_MISS];
  assign miss_cnt_o    = vld[SLOT_MISS];

  // R9
  rsp_unblock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_match |=> !blocked_o);

  // R6
  err_retry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_gnt_i && bus_err_i && !sq_valid_i |=> bus_req_o);

  // R3
  nofill_noblock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_req_i && miss_wr_i && !wr_alloc_i && !blocked_o |=> !blocked_o);

  // R2
  fill_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req && !blocked_o |=> blocked_o && miss_cnt_o == 1'b1);
endmodule

// File: tb/miss_buf_test.sv
module miss_buf_test;
  localparam int AW = 32;
  localparam int TW = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic wr_alloc, miss_req, miss_wr, wb_req, gnt, berr, rsp_v, sq_v;
  logic [AW-1:0] miss_addr, wb_addr, rsp_addr, lk_addr;
  logic [TW-1:0] miss_tid, wb_tid, sq_tid;
  logic err, breq, bsel, fwd, lkm, lkw, blocked;
  logic [AW-1:0] baddr;
  logic [TW-1:0] btid;
  logic [1:0] bcmd;
  logic [0:0] mcnt;

  miss_buf #(.AW(AW), .TW(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_alloc_i(wr_alloc),
    .miss_req_i(miss_req), .miss_wr_i(miss_wr), .miss_addr_i(miss_addr), .miss_tid_i(miss_tid),
    .wb_req_i(wb_req), .wb_addr_i(wb_addr), .wb_tid_i(wb_tid), .err_o(err),
    .bus_req_o(breq), .bus_sel_o(bsel), .bus_addr_o(baddr), .bus_tid_o(btid), .bus_cmd_o(bcmd),
    .bus_gnt_i(gnt), .bus_err_i(berr), .rsp_valid_i(rsp_v), .rsp_addr_i(rsp_addr),
    .rsp_fwd_o(fwd), .sq_valid_i(sq_v), .sq_tid_i(sq_tid), .lk_addr_i(lk_addr),
    .lk_miss_hit_o(lkm), .lk_wb_hit_o(lkw), .blocked_o(blocked), .miss_cnt_o(mcnt)
  );

  int total = 0, fails = 0;

  // reference state
  logic m_v, m_b, m_t, w_v;
  logic [AW-1:0] m_a, w_a;
  logic [TW-1:0] m_i, w_i;
  logic [1:0] m_c, w_c;

  task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    miss_req = 0; miss_wr = 0; wb_req = 0; gnt = 0; berr = 0; rsp_v = 0; sq_v = 0;
    miss_addr = 0; miss_tid = 0; wb_addr = 0; wb_tid = 0; rsp_addr = 0; sq_tid = 0;
    lk_addr = 0;
  endtask

  function automatic logic e_req(); return (m_v && !m_b) || w_v; endfunction

  // inputs set just after a falling edge; ends at the next falling edge
  task automatic tick();
    logic fill, nofill, e_err, pick_w, snd, hit, sqm, sqw, am, aw;
    #2;
    fill   = miss_req && (!miss_wr || wr_alloc);
    nofill = miss_req && miss_wr && !wr_alloc;
    e_err  = (fill && m_v) || (wb_req && w_v) || (nofill && (w_v || wb_req));
    pick_w = w_v;
    snd    = e_req() && gnt && !berr;
    hit    = rsp_v && m_v && m_b && (rsp_addr == m_a);
    chk("R4 err", AW'(err), AW'(e_err));
    chk("R5 bus_req", AW'(breq), AW'(e_req()));
    if (e_req()) begin
      chk("R5 sel", AW'(bsel), AW'(pick_w));
      chk("R5 addr", baddr, pick_w ? w_a : m_a);
      chk("R5 tid", AW'(btid), AW'(pick_w ? w_i : m_i));
      chk("R2 cmd", AW'(bcmd), AW'(pick_w ? w_c : m_c));
    end
    chk("R9 fwd", AW'(fwd), AW'(hit && m_t));
    chk("R11 lk_miss", AW'(lkm), AW'(m_v && lk_addr == m_a));
    chk("R11 lk_wb", AW'(lkw), AW'(w_v && lk_addr == w_a));
    am  = fill && !m_v;
    aw  = !w_v && (wb_req || nofill);
    sqm = sq_v && m_v && m_i == sq_tid;
    sqw = sq_v && w_v && w_i == sq_tid;
    if (am) begin
      m_v = 1; m_b = 0; m_t = 1; m_a = miss_addr; m_i = miss_tid; m_c = miss_wr ? 2'd1 : 2'd0;
    end else if (hit) begin
      m_v = 0; m_b = 0;
    end else if (sqm) begin
      if (m_b) m_t = 0; else m_v = 0;
    end else if (snd && !pick_w) m_b = 1;
    if (aw) begin
      w_v = 1; w_a = wb_req ? wb_addr : miss_addr; w_i = wb_req ? wb_tid : miss_tid;
      w_c = wb_req ? 2'd3 : 2'd2;
    end else if (sqw) w_v = 0;
    else if (snd && pick_w) w_v = 0;
    @(negedge clk);
    chk("R2 blocked", AW'(blocked), AW'(m_v));
    chk("R2 miss_cnt", AW'(mcnt), AW'(m_v));
  endtask

  initial begin
    #3000000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idle(); wr_alloc = 1;
    m_v = 0; m_b = 0; m_t = 0; w_v = 0; m_a = 0; w_a = 0; m_i = 0; w_i = 0; m_c = 0; w_c = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    // R1
    chk("R1 blocked", AW'(blocked), 0);
    chk("R1 bus_req", AW'(breq), 0);
    chk("R1 miss_cnt", AW'(mcnt), 0);

    // R2: read miss
    miss_req = 1; miss_addr = 5; miss_tid = 1; tick(); idle();
    chk("R2 blocked after miss", AW'(blocked), 1);
    // R4: second fill miss refused
    miss_req = 1; miss_addr = 6; tick(); idle();
    lk_addr = 5; #1; chk("R4 slot kept", AW'(lkm), 1);
    // R6: errored send retried
    gnt = 1; berr = 1; tick(); idle(); #1;
    chk("R6 still pending", AW'(breq), 1);
    chk("R6 same code", AW'(bcmd), 0);
    // R8
    gnt = 1; tick(); idle(); #1;
    chk("R8 not pending", AW'(breq), 0);
    chk("R8 blocked", AW'(blocked), 1);
    // R9: wrong address ignored
    rsp_v = 1; rsp_addr = 6; tick(); idle();
    chk("R9 mismatch ignored", AW'(blocked), 1);
    rsp_v = 1; rsp_addr = 5; #1;
    chk("R9 forwarded", AW'(fwd), 1);
    tick(); idle();
    chk("R9 unblocked", AW'(blocked), 0);

    // R3: no-fill write
    wr_alloc = 0; miss_req = 1; miss_wr = 1; miss_addr = 3; tick(); idle(); #1;
    chk("R3 not blocked", AW'(blocked), 0);
    chk("R3 write code", AW'(bcmd), 2);
    // R4: writeback collides with occupied write slot
    wb_req = 1; wb_addr = 2; tick(); idle();
    // R7
    gnt = 1; tick(); idle(); #1;
    chk("R7 write freed", AW'(breq), 0);

    // R5: both pending, write slot first
    wr_alloc = 1; miss_req = 1; miss_addr = 4; miss_tid = 2; wb_req = 1; wb_addr = 7; wb_tid = 3;
    tick(); idle(); #1;
    chk("R5 wb first", AW'(bsel), 1);
    chk("R5 wb code", AW'(bcmd), 3);
    // R10: squash unsent wb beats send
    sq_v = 1; sq_tid = 3; gnt = 1; tick(); idle(); #1;
    chk("R10 wb squashed", AW'(lkw), 0);
    chk("R10 miss offered", AW'(bsel), 0);
    gnt = 1; tick(); idle();
    sq_v = 1; sq_tid = 2; tick(); idle();
    rsp_v = 1; rsp_addr = 4; #1;
    chk("R10 no forward", AW'(fwd), 0);
    tick(); idle();
    chk("R10 freed", AW'(blocked), 0);

    // random traffic
    void'($urandom(32'h5eed));
    for (int n = 0; n < 3000; n++) begin
      if (n % 300 == 0) wr_alloc = 1'($urandom_range(0, 1));
      miss_req  = ($urandom_range(0, 99) < 30);
      miss_wr   = 1'($urandom_range(0, 1));
      miss_addr = AW'($urandom_range(0, 7));
      miss_tid  = TW'($urandom_range(0, 3));
      wb_req    = ($urandom_range(0, 99) < 15);
      wb_addr   = AW'($urandom_range(0, 7));
      wb_tid    = TW'($urandom_range(0, 3));
      gnt       = ($urandom_range(0, 99) < 40);
      berr      = ($urandom_range(0, 99) < 25);
      rsp_v     = ($urandom_range(0, 99) < 30);
      rsp_addr  = ($urandom_range(0, 4) != 0) ? m_a : AW'($urandom_range(0, 7));
      sq_v      = ($urandom_range(0, 99) < 5);
      sq_tid    = TW'($urandom_range(0, 3));
      lk_addr   = AW'($urandom_range(0, 7));
      tick();
    end
    idle();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule